// File: doc/BRIEF.md
# Gate-Segmented Byte-Lane Reduction Unit

This unit reduces a wide operand to one bit per byte lane. Runtime gate bits sit at the seams between adjacent lanes and split the word into partitions. A partition is any contiguous run of whole lanes. Within each partition the unit folds every operand bit with a selected operator: all-ones, any-one or odd parity. It then copies that one bit into the result position of every lane the partition covers. A SIMD datapath can therefore use one set of wires to produce a per-lane flag that is right for 8x8, 4x16, 2x32, 1x64 or any mixed split.

Each lane is first folded on its own. The lane bits are then merged with their neighbours in two segmented prefix chains, one running upward and one running downward. A set gate restarts both chains. The two chains meet at each lane, so each lane sees its whole partition. The unit holds no state. The result follows the inputs within the same cycle.

Top module: `psimd_reduce`

## Requirements
- R1: Gate bit `split[k]` = 1 places a partition boundary between lane k and lane k+1, so data in one lane has no effect on the result bits of the other. Gate bit `split[k]` = 0 joins the two lanes into one partition.
- R2: The lowest and highest lanes are always partition edges and the word does not wrap. With all gate bits 0, the whole operand is one partition.
- R3: With `op` = 2'b00 (all-ones), a lane's result bit is 1 exactly when every operand bit of its partition is 1.
- R4: With `op` = 2'b01 (any-one), a lane's result bit is 1 exactly when at least one operand bit of its partition is 1.
- R5: With `op` = 2'b10 (parity), a lane's result bit is the XOR of all operand bits of its partition.
- R6: With `op` = 2'b11, the result is all zeros regardless of operand and gates.
- R7: Every lane in a partition carries the same result bit.
- R8: Partitions of every length from 1 to 8 lanes, at every offset, and every mix of lengths reduce correctly. Lane k occupies operand bits [8k+7:8k], and its result sits in bit k.
- R9: The unit is purely combinational. The result reflects the current inputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand | input | LANES*LANE_W (64) | Data word; lane k is bits [8k+7:8k] |
| split | input | LANES-1 (7) | Seam gates; bit k separates lane k from lane k+1 |
| op | input | 2 | 00 all-ones, 01 any-one, 10 parity, 11 zero |
| result | output | LANES (8) | One reduction bit per lane, shared across each partition |

## Verification
Every result bit is due zero cycles after a stimulus, because no register lies between any input and the output. The bench applies each vector and samples one nanosecond later, well before the next clock edge. A dedicated check changes the operand between clock edges and reads the new result before any edge arrives. The exhaustive sweep over all gate patterns and operations compares against a model that searches for partition edges lane by lane, rather than one built from prefix chains.

// File: rtl/psimd_reduce.sv
module psimd_reduce #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8
) (
  input  logic [LANES*LANE_W-1:0] operand,
  input  logic [LANES-2:0]        split,
  input  logic [1:0]              op,
  output logic [LANES-1:0]        result
);
  localparam logic [1:0] OP_ALL = 2'b00;
  localparam logic [1:0] OP_ANY = 2'b01;
  localparam logic [1:0] OP_PAR = 2'b10;

  logic [LANES-1:0] lane_v, up, dn;
  logic [LANES:0]   brk;

  assign brk = {1'b1, split, 1'b1};

  function automatic logic merge(input logic a, input logic b, input logic [1:0] o);
    case (o)
      OP_ALL:  merge = a & b;
      OP_ANY:  merge = a | b;
      OP_PAR:  merge = a ^ b;
      default: merge = 1'b0;
    endcase
  endfunction

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] byt;
    assign byt = operand[i*LANE_W +: LANE_W];
    assign lane_v[i] = (op == OP_ALL) ? &byt :
                       (op == OP_ANY) ? |byt :
                       (op == OP_PAR) ? ^byt : 1'b0;

    if (i == 0) begin : g_up0
      assign up[i] = lane_v[i];
    end else begin : g_upn
      assign up[i] = brk[i] ? lane_v[i] : merge(up[i-1], lane_v[i], op);
    end

    if (i == LANES-1) begin : g_top
      assign dn[i]     = lane_v[i];
      assign result[i] = up[i];
    end else begin : g_mid
      assign dn[i]     = brk[i+1] ? lane_v[i] : merge(dn[i+1], lane_v[i], op);
      assign result[i] = brk[i+1] ? up[i] : merge(up[i], dn[i+1], op);
    end
  end
endmodule

// File: rtl/psimd_reduce_chk.sv
module psimd_reduce_chk #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8
) (
  input logic [LANES*LANE_W-1:0] operand,
  input logic [LANES-2:0]        split,
  input logic [1:0]              op,
  input logic [LANES-1:0]        result
);
  logic [LANES:0] edges;
  assign edges = {1'b1, split, 1'b1};

  always_comb begin
    if (op == 2'b11)
      assert_idle_zero_R6: assert (result == '0);
    for (int i = 0; i < LANES; i++) begin
      if (i < LANES-1 && !edges[i+1] && op != 2'b11)
        assert_span_match_R7: assert (result[i] == result[i+1]);
      if (op == 2'b00 && operand[i*LANE_W +: LANE_W] != {LANE_W{1'b1}})
        assert_all_clear_R3: assert (result[i] == 1'b0);
      if (op == 2'b01 && operand[i*LANE_W +: LANE_W] != '0)
        assert_any_set_R4: assert (result[i] == 1'b1);
      if (op == 2'b10 && edges[i] && edges[i+1])
        assert_solo_parity_R5: assert (result[i] == ^operand[i*LANE_W +: LANE_W]);
    end
  end
endmodule

bind psimd_reduce psimd_reduce_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .operand(operand), .split(split), .op(op), .result(result)
);

// File: tb/tb_psimd_reduce.sv
module tb_psimd_reduce;
  logic clk = 1'b0;
  always #10ns clk = ~clk;

  logic [63:0] operand;
  logic [6:0]  split;
  logic [1:0]  op;
  logic [7:0]  result;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  psimd_reduce dut (.operand(operand), .split(split), .op(op), .result(result));

  localparam int NV = 12;
  localparam logic [1:0]  V_OP [NV] = '{2'd0, 2'd0, 2'd0, 2'd1, 2'd1, 2'd1,
                                        2'd2, 2'd2, 2'd3, 2'd0, 2'd2, 2'd1};
  localparam logic [6:0]  V_SP [NV] = '{7'h00, 7'h00, 7'h7F, 7'h00, 7'h01, 7'h00,
                                        7'h7F, 7'h08, 7'h55, 7'h25, 7'h00, 7'h40};
  localparam logic [63:0] V_D  [NV] = '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFE,
                                        64'hFFFF_FFFF_FFFF_FFFE, 64'h0,
                                        64'h0000_0000_0000_0100, 64'h8000_0000_0000_0000,
                                        64'h0000_0000_0000_0003, 64'h0000_0000_0000_0007,
                                        64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FF7F_FFFF_FFFF,
                                        64'h0100_0000_0000_0001, 64'h8000_0000_0000_0000};
  localparam logic [7:0]  V_EX [NV] = '{8'hFF, 8'h00, 8'hFE, 8'h00, 8'hFE, 8'hFF,
                                        8'h00, 8'h0F, 8'h00, 8'hC7, 8'h00, 8'h80};
  // Row tags: R3 R3 R8 R4 R1 R2 R5 R5 R6 R7 R5 R1
  localparam int V_REQ [NV] = '{3, 3, 8, 4, 1, 2, 5, 5, 6, 7, 5, 1};

  function automatic logic [7:0] model(logic [63:0] d, logic [6:0] s, logic [1:0] o);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      int lo, hi;
      logic acc;
      lo = i; hi = i;
      while (lo > 0 && !s[lo-1]) lo--;
      while (hi < 7 && !s[hi]) hi++;
      acc = (o == 2'd0);
      for (int b = lo*8; b <= hi*8+7; b++)
        case (o)
          2'd0: acc = acc & d[b];
          2'd1: acc = acc | d[b];
          2'd2: acc = acc ^ d[b];
          default: acc = 1'b0;
        endcase
      r[i] = acc;
    end
    return r;
  endfunction

  task automatic check(string tag, logic [7:0] exp);
    n_run++;
    if (result !== exp) begin
      n_fail++;
      $display("FAIL %s: result=%h expected=%h (op=%0d split=%h operand=%h)",
               tag, result, exp, op, split, operand);
    end
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] x;
    operand = 64'hFFFF_FFFF_FFFF_FFFF; split = 7'h00; op = 2'b11;
    #1ns check("R6 initial state", 8'h00);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      operand = V_D[v]; split = V_SP[v]; op = V_OP[v];
      #1ns check($sformatf("R%0d vector %0d", V_REQ[v], v), V_EX[v]);
    end

    // R9: new operand seen without any clock edge
    @(posedge clk); #2ns;
    op = 2'd1; split = 7'h7F; operand = 64'h0;
    #1ns check("R9 zero before edge", 8'h00);
    operand = 64'h0000_0000_0000_1000;
    #1ns check("R9 update before edge", 8'h02);

    // R8: all gate patterns, all operations, varied data
    x = 64'h9E37_79B9_7F4A_7C15;
    for (int s = 0; s < 128; s++) begin
      for (int o = 0; o < 4; o++) begin
        @(negedge clk);
        x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
        operand = (s % 3 == 0) ? (x | 64'hFFFF_FFFF_0000_FFFF) : x;
        split = 7'(s); op = 2'(o);
        #1ns check("R8 sweep", model(operand, split, op));
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule